// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one read burst on a memory with a synchronous DRAM-style interface. A read request carries a starting column, a three-bit burst length code and a one-bit ordering select. Starting on the clock after the request is accepted, the block presents one column address per cycle with a valid flag. A last flag marks the final beat.

The burst stays inside an aligned block whose size equals the burst length. Only the low in-block bits move. In sequential order they count up from the start position modulo the length. In interleaved order they are the start position XOR the beat index. A full-page mode walks the whole 256-column page in sequential order, wraps from the top column to column zero, and runs until the terminate input stops it. The terminate input can also cut a fixed-length burst short. A new request always pre-empts the burst in progress. Illegal settings are refused with a one-cycle error pulse.

Top module: `burst_col_seq`

## Requirements
- R1: Length code 0 gives 1 beat, code 1 gives 2, code 2 gives 4 and code 3 gives 8 beats. Code 7 selects full page. Exactly the coded number of valid beats is produced, and `col_last` is high on the final one.
- R2: During a burst the column bits above the in-block field equal those of the start column. The in-block field is 1 bit for length 2, 2 bits for length 4, 3 bits for length 8 and all 8 bits for full page.
- R3: With `burst_type` = 0 (sequential), beat k carries the start's in-block field plus k, modulo the burst length. The burst wraps to the start of the same aligned block and never carries into the upper bits.
- R4: With `burst_type` = 1 (interleaved), beat k carries the start's in-block field XOR k.
- R5: A full-page sequential burst steps through the page, wraps from column 255 to column 0, and continues until terminated.
- R6: A request with length code 4, 5 or 6, or with code 7 together with `burst_type` = 1, starts no burst. It raises `cfg_err` for exactly the next cycle and leaves any running burst untouched.
- R7: If `terminate` is high on a clock edge while a burst is active and its present beat is not the last, the beat presented after that edge is the final one and carries `col_last`.
- R8: A legal request that arrives during a burst abandons the old burst. The first beat of the new burst appears on the next clock.
- R9: While `rst_n` is low on a clock edge, `col_valid`, `col_last` and `cfg_err` are low after that edge.
- R10: `col_last` is never high without `col_valid`. After a last beat, `col_valid` drops unless a new legal request was accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request, sampled each rising edge |
| start_col | input | 8 | Starting column of the request |
| len_code | input | 3 | Burst length code (0,1,2,3 legal fixed lengths, 7 full page) |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| terminate | input | 1 | Ends the running burst after one more beat |
| col_out | output | 8 | Column address of the present beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Present beat is the final beat |
| cfg_err | output | 1 | One-cycle pulse for a refused request |

## Verification
A request sampled on edge N yields beat k after edge N+k, and a refused request yields `cfg_err` after edge N alone. A terminate sampled on edge E marks the beat after E as last. The bench drives inputs on falling edges and samples every output on falling edges, half a cycle after the edge that produced it. For each request the driver pushes the expected beat list into a queue, and the monitor pops one entry for every valid beat it observes. Any valid beat that arrives with an empty queue is a failure, and so is a queue still holding entries once the burst should have finished.

// File: rtl/bcs_pkg.sv
// Package: shared encodings for the burst column address sequencer.
// Assumes the length code is three bits and the ordering select is one bit.
package bcs_pkg;

    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_code_e;

    typedef enum logic {
        ORDER_SEQ   = 1'b0,
        ORDER_INTLV = 1'b1
    } order_e;

endpackage

// File: rtl/bcs_len_decode.sv
// Module: bcs_len_decode
// Turns the length code and ordering select into an in-block mask, a full-page
// flag and a refusal flag. Purely combinational. Assumes COL_W >= 3.
module bcs_len_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    input  logic             order,
    output logic [COL_W-1:0] mask,
    output logic             full_page,
    output logic             bad
);

    localparam logic [COL_W-1:0] MASK_PAGE = '1;

    // Decode the length code into the set of in-block bits.
    always_comb begin
        mask      = '0;
        full_page = 1'b0;
        bad       = 1'b0;
        case (len_code)
            BLEN_1:    mask = COL_W'(0);
            BLEN_2:    mask = COL_W'(1);
            BLEN_4:    mask = COL_W'(3);
            BLEN_8:    mask = COL_W'(7);
            BLEN_PAGE: begin
                mask      = MASK_PAGE;
                full_page = 1'b1;
                bad       = (order == ORDER_INTLV);
            end
            default:   bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/bcs_beat_ctrl.sv
// Module: bcs_beat_ctrl
// Beat counter and burst state. It counts beats from zero after an accepted
// request, decides which beat is last (length reached or terminate seen), and
// pulses the error flag for a refused request. Assumes load and reject are
// never high together.
module bcs_beat_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             reject,
    input  logic [COL_W-1:0] mask_in,
    input  logic             page_in,
    input  logic             terminate,
    output logic             active,
    output logic             last,
    output logic             err,
    output logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] mask_q
);

    logic             page_q;
    logic [COL_W-1:0] idx_nxt;

    // Index of the beat that would follow the present one.
    always_comb idx_nxt = idx + COL_W'(1);

    // Burst state: start, step, flag the final beat, and stop after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            last   <= 1'b0;
            err    <= 1'b0;
            idx    <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
        end else begin
            err <= reject;
            if (load) begin
                active <= 1'b1;
                idx    <= '0;
                mask_q <= mask_in;
                page_q <= page_in;
                last   <= (mask_in == '0);
            end else if (active) begin
                if (last) begin
                    active <= 1'b0;
                    last   <= 1'b0;
                end else begin
                    idx  <= idx_nxt;
                    last <= terminate || (!page_q && (idx_nxt == mask_q));
                end
            end
        end
    end

    // R10: a last beat is always a valid beat.
    p_last_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> active);

    // R7: terminate on a non-final beat makes the following beat final.
    p_terminate_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active && !last && terminate && !load |=> active && last);

endmodule

// File: rtl/bcs_addr_gen.sv
// Module: bcs_addr_gen
// Holds the start column and ordering of the running burst and forms the
// column of beat idx: upper bits fixed, in-block bits either start+idx or
// start^idx under the mask. The ordering variant is picked by ORDER_FIXED:
// a negative value keeps it run-time selectable.
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W       = 8,
    parameter int ORDER_FIXED = -1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] start_in,
    input  logic             order_in,
    input  logic [COL_W-1:0] mask,
    input  logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] col,
    output logic             order_q
);

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] xor_low;

    // Capture the start column and ordering when a burst is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= 1'b0;
        end else if (load) begin
            base_q  <= start_in;
            order_q <= order_in;
        end
    end

    // Candidate in-block fields for both orderings.
    always_comb begin
        seq_low = (base_q + idx) & mask;
        xor_low = (base_q ^ idx) & mask;
    end

    generate
        if (ORDER_FIXED < 0) begin : g_both
            // Select the in-block field by the captured ordering.
            always_comb col = (base_q & ~mask) |
                              ((order_q == ORDER_INTLV) ? xor_low : seq_low);
        end else if (ORDER_FIXED == 0) begin : g_seq_only
            // Sequential ordering only.
            always_comb col = (base_q & ~mask) | seq_low;
        end else begin : g_intlv_only
            // Interleaved ordering only.
            always_comb col = (base_q & ~mask) | xor_low;
        end
    endgenerate

endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Column address sequencer for one read burst. A request sampled on edge N
// shows beat k after edge N+k. Illegal requests pulse cfg_err after edge N.
// Assumes start_col, len_code and burst_type are meaningful whenever rd_req
// is high.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             burst_type,
    input  logic             terminate,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last,
    output logic             cfg_err
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_bad;
    logic             accept;
    logic             reject;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] mask_q;
    logic             order_q;

    // Split a request into accepted and refused.
    always_comb begin
        accept = rd_req && !dec_bad;
        reject = rd_req && dec_bad;
    end

    bcs_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (len_code),
        .order     (burst_type),
        .mask      (dec_mask),
        .full_page (dec_page),
        .bad       (dec_bad)
    );

    bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .reject    (reject),
        .mask_in   (dec_mask),
        .page_in   (dec_page),
        .terminate (terminate),
        .active    (col_valid),
        .last      (col_last),
        .err       (cfg_err),
        .idx       (beat_idx),
        .mask_q    (mask_q)
    );

    bcs_addr_gen #(.COL_W(COL_W), .ORDER_FIXED(-1)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .start_in (start_col),
        .order_in (burst_type),
        .mask     (mask_q),
        .idx      (beat_idx),
        .col      (col_out),
        .order_q  (order_q)
    );

    // R9: reset clears the outputs on the next edge.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> !col_valid && !col_last && !cfg_err);

    // R6: a refused request starts nothing and pulses the error flag.
    p_refuse_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && dec_bad && !col_valid |=> cfg_err && !col_valid);

    // R8: a legal request shows its start column on the next beat.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> col_valid && (col_out == $past(start_col)));

    // R10: the burst stops after its last beat unless a new one is accepted.
    p_stop_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && col_last && !rd_req |=> !col_valid);

    // R3: sequential beats step by one inside the block.
    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !col_last && !rd_req && (order_q == ORDER_SEQ)
        |=> (((col_out - $past(col_out)) & mask_q) == COL_W'(1)));

    // R2: the bits above the block stay fixed during a burst.
    p_block_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !col_last && !rd_req
        |=> (((col_out ^ $past(col_out)) & ~mask_q) == '0));

endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       burst_type = 1'b0;
    logic       terminate = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       col_last;
    logic       cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] col;
        logic       last;
        string      tag;
    } beat_t;

    beat_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .start_col  (start_col),
        .len_code   (len_code),
        .burst_type (burst_type),
        .terminate  (terminate),
        .col_out    (col_out),
        .col_valid  (col_valid),
        .col_last   (col_last),
        .cfg_err    (cfg_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [7:0] code_mask(input logic [2:0] code);
        case (code)
            3'd1: return 8'h01;
            3'd2: return 8'h03;
            3'd3: return 8'h07;
            3'd7: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Expected column of beat k from the ordering rules (R2, R3, R4).
    function automatic logic [7:0] exp_col(input logic [7:0] s, input int k,
                                           input logic [2:0] code, input logic ord);
        logic [7:0] m;
        logic [7:0] kk;
        m  = code_mask(code);
        kk = 8'(k);
        if (ord) return (s & ~m) | ((s ^ kk) & m);
        return (s & ~m) | ((s + kk) & m);
    endfunction

    task automatic push_beats(input logic [7:0] s, input logic [2:0] code,
                              input logic ord, input int first, input int n,
                              input bit mark_last, input string tag);
        for (int k = first; k < first + n; k++) begin
            beat_t b;
            b.col  = exp_col(s, k, code, ord);
            b.last = mark_last && (k == first + n - 1);
            b.tag  = tag;
            exp_q.push_back(b);
        end
    endtask

    // Raise a request for one cycle; returns just after the sampling edge.
    task automatic send_req(input logic [7:0] s, input logic [2:0] code,
                            input logic ord);
        rd_req     = 1'b1;
        start_col  = s;
        len_code   = code;
        burst_type = ord;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic drained(input string tag);
        check(exp_q.size() == 0, tag, "beats still expected", exp_q.size(), 0);
    endtask

    task automatic fixed_burst(input logic [7:0] s, input logic [2:0] code,
                               input logic ord, input string tag);
        int n;
        n = int'(code_mask(code)) + 1;
        push_beats(s, code, ord, 0, n, 1'b1, tag);
        send_req(s, code, ord);
        repeat (n + 1) @(negedge clk);
        drained(tag);
    endtask

    task automatic refused(input logic [2:0] code, input logic ord);
        send_req(8'h5A, code, ord);
        check(cfg_err == 1'b1, "R6", "cfg_err pulse", cfg_err, 1);
        check(col_valid == 1'b0, "R6", "valid after refusal", col_valid, 0);
        @(negedge clk);
        check(cfg_err == 1'b0, "R6", "cfg_err second cycle", cfg_err, 0);
    endtask

    // Monitor: every valid beat pops one expected entry (R10 if none left).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(!(col_last && !col_valid), "R10", "last without valid", col_last, 0);
            if (col_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected beat col", col_out, 0);
                end else begin
                    beat_t b;
                    b = exp_q.pop_front();
                    check(col_out == b.col, b.tag, "column", col_out, b.col);
                    check(col_last == b.last, b.tag, "last flag", col_last, b.last);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(col_valid == 1'b0, "R9", "valid in reset", col_valid, 0);
        check(col_last == 1'b0, "R9", "last in reset", col_last, 0);
        check(cfg_err == 1'b0, "R9", "err in reset", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        fixed_burst(8'h33, 3'd0, 1'b0, "R1");
        fixed_burst(8'h25, 3'd1, 1'b0, "R3");
        fixed_burst(8'h7E, 3'd2, 1'b0, "R3");
        fixed_burst(8'hFB, 3'd3, 1'b0, "R2");
        fixed_burst(8'h35, 3'd3, 1'b1, "R4");
        fixed_burst(8'h0A, 3'd2, 1'b1, "R4");
        fixed_burst(8'h81, 3'd1, 1'b1, "R4");

        // R5: full page from 250, wraps past 255, terminate seen with beat 7.
        push_beats(8'd250, 3'd7, 1'b0, 0, 9, 1'b1, "R5");
        send_req(8'd250, 3'd7, 1'b0);
        repeat (7) @(negedge clk);
        terminate = 1'b1;
        @(negedge clk);
        terminate = 1'b0;
        repeat (2) @(negedge clk);
        drained("R5");

        // R7: length 8 from 5 cut short while beat 2 is shown.
        push_beats(8'h05, 3'd3, 1'b0, 0, 4, 1'b1, "R7");
        send_req(8'h05, 3'd3, 1'b0);
        repeat (2) @(negedge clk);
        terminate = 1'b1;
        @(negedge clk);
        terminate = 1'b0;
        repeat (2) @(negedge clk);
        drained("R7");

        // R6: refused settings, alone and during a running burst.
        refused(3'd4, 1'b0);
        refused(3'd5, 1'b1);
        refused(3'd6, 1'b0);
        refused(3'd7, 1'b1);
        repeat (2) @(negedge clk);
        drained("R6");
        push_beats(8'h60, 3'd2, 1'b0, 0, 4, 1'b1, "R6");
        send_req(8'h60, 3'd2, 1'b0);
        send_req(8'h11, 3'd5, 1'b0);
        check(cfg_err == 1'b1, "R6", "cfg_err during burst", cfg_err, 1);
        repeat (4) @(negedge clk);
        drained("R6");

        // R8: new request while beat 2 of a length-8 burst is shown.
        push_beats(8'h10, 3'd3, 1'b0, 0, 3, 1'b0, "R8");
        push_beats(8'h43, 3'd2, 1'b1, 0, 4, 1'b1, "R8");
        send_req(8'h10, 3'd3, 1'b0);
        repeat (2) @(negedge clk);
        send_req(8'h43, 3'd2, 1'b1);
        repeat (5) @(negedge clk);
        drained("R8");

        // R10: back-to-back single beats, then silence.
        push_beats(8'h20, 3'd0, 1'b0, 0, 1, 1'b1, "R10");
        push_beats(8'h21, 3'd0, 1'b0, 0, 1, 1'b1, "R10");
        send_req(8'h20, 3'd0, 1'b0);
        send_req(8'h21, 3'd0, 1'b0);
        repeat (3) @(negedge clk);
        drained("R10");

        finish_run();
    end

endmodule